// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps the wall-clock time and a Gregorian date, every field coded in BCD. The fields are seconds, minutes, hours with an AM/PM flag, day of week, date, month, year and century. The calendar covers 1900 to 2099 and wraps from the end of 2099 back to 1900. The counters advance on a one-second tick. A generate option selects the source of that tick. In one variant a free-running power-of-two prescaler makes the tick from a slow reference clock, and with the default width of 15 bits a 32.768 kHz clock gives one tick per second. In the other variant the tick input is used directly as the second tick. The hour counter runs from 00 to 23, or from 01 to 12 with an AM/PM flag when 12-hour counting is selected.

Software stops the counters before it changes them. One hold input freezes the three time-of-day counters. A separate hold input freezes only the calendar counters, and the time of day keeps running. The block raises an acknowledge one cycle after a hold request is seen. A packed 32-bit word loads into a group of counters only while that group is held and the acknowledge is high. If the time of day passes midnight while the calendar is held, the block records it and advances the date once when the hold is released. The block does not check the loaded values, match alarms or raise interrupts.

Top module: `bcd_timekeeper`

## Requirements
- R1: After reset the time word reads 0x00000000 and the calendar word reads 0x01819819. That value is Thursday-coded day 4, 01 January 1998, with the century field at 19.
- R2: Time word layout: seconds in bits [6:0], minutes in [14:8], hour in [21:16], PM flag in bit 22 (1 = PM). Calendar word layout: century in [6:0], two-digit year in [15:8], month in [20:16], day of week in [23:21], date in [29:24]. All other bits read 0, even when a load word has them set.
- R3: Seconds count 00 to 59 in BCD on each tick. Minutes step when seconds wrap from 59 to 00, and they wrap from 59 to 00 in the same way.
- R4: With the 12-hour select low, the hour counts 00 to 23. The step from 23:59:59 to 00:00:00 advances the date by one day.
- R5: With the 12-hour select high, the hour goes 12, 01, ..., 11, then 12. The PM flag toggles on the step from 11 to 12. The step from 11:59:59 PM to 12:00:00 AM advances the date.
- R6: The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months. In month 02 it wraps after 29 when the year is a multiple of 4 (00 included) and after 28 otherwise.
- R7: When the date wraps, the month steps. Month 12 wraps to 01 and steps the year. Year 99 wraps to 00 and moves the century from 19 to 20, or from 20 back to 19.
- R8: Day of week steps 1 to 7 and back to 1 on every date advance. It does not take part in the date wrap.
- R9: While the time hold is high, the seconds, minutes and hours do not change. While the calendar hold is high, the calendar fields do not change and the time of day keeps counting.
- R10: A midnight that passes while the calendar is held advances the date exactly once, on the clock edge after the calendar hold falls.
- R11: The acknowledge output goes high on the clock edge after either hold is high and low on the edge after both are low. A time load takes effect only when the time hold and the acknowledge are both high, and a calendar load only when the calendar hold and the acknowledge are both high. Any other load leaves every field unchanged.
- R12: In the prescaler variant with the reference enable held high, the second tick output pulses for one cycle in every 2^DIV_W cycles, first after 2^DIV_W - 1 cycles from reset, and each pulse advances the seconds.
- R13: A calendar load discards a midnight recorded earlier. A midnight that arrives in the same cycle as the load is kept and applied after release, on top of the loaded date.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock (reference clock in the prescaler variant) |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in_i | input | 1 | Reference enable (prescaler variant) or one-second tick (bypass variant) |
| mode_12h_i | input | 1 | 1 selects 12-hour counting with PM flag |
| time_hold_i | input | 1 | Freeze the time-of-day counters |
| cal_hold_i | input | 1 | Freeze the calendar counters |
| upd_ack_o | output | 1 | Hold acknowledged; loads are accepted |
| time_ld_i | input | 1 | Load the time word |
| time_wdata_i | input | 32 | Packed time word to load |
| cal_ld_i | input | 1 | Load the calendar word |
| cal_wdata_i | input | 32 | Packed calendar word to load |
| time_o | output | 32 | Packed current time |
| cal_o | output | 32 | Packed current calendar |
| sec_tick_o | output | 1 | One-cycle second tick |

## Verification
The case that needs the most care is a calendar load landing in the same cycle as a midnight carry from the still-running time counters. The bench sets up this case as follows. It holds the calendar, loads 23:59:59, and then drives the calendar load together with a tick on one edge. The bench then expects to read back the loaded date unchanged, with the time at 00:00:00. After the hold is released it expects exactly one added day, which also checks the leap-day step into 29 February. A second case separates a midnight recorded before a load from the load itself and expects that midnight to be lost.

// File: rtl/bcd_tk_pkg.sv
package bcd_tk_pkg;

   localparam int WORD_W = 32;

   typedef struct packed {
      logic       pm;
      logic [5:0] hour;
      logic [6:0] min;
      logic [6:0] sec;
   } tk_time_t;

   typedef struct packed {
      logic [5:0] date;
      logic [2:0] dow;
      logic [4:0] month;
      logic [7:0] year;
      logic [6:0] cent;
   } tk_cal_t;

   // BCD increment of a two-digit value; no wrap handling here
   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      logic [7:0] r;
      if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
      else                r = {v[7:4], v[3:0] + 4'd1};
      return r;
   endfunction

   // 10*t + u is congruent to 2*t + u modulo 4
   function automatic logic year_is_leap(input logic [7:0] y);
      logic [4:0] s;
      s = {y[7:4], 1'b0} + {1'b0, y[3:0]};
      return (s[1:0] == 2'b00);
   endfunction

   function automatic logic [5:0] month_last_date(input logic [4:0] m, input logic [7:0] y);
      logic [5:0] r;
      case (m)
         5'h02:                      r = year_is_leap(y) ? 6'h29 : 6'h28;
         5'h04, 5'h06, 5'h09, 5'h11: r = 6'h30;
         default:                    r = 6'h31;
      endcase
      return r;
   endfunction

   function automatic tk_time_t unpack_time(input logic [WORD_W-1:0] w);
      tk_time_t t;
      t.sec  = w[6:0];
      t.min  = w[14:8];
      t.hour = w[21:16];
      t.pm   = w[22];
      return t;
   endfunction

   function automatic logic [WORD_W-1:0] pack_time(input tk_time_t t);
      return {9'd0, t.pm, t.hour, 1'b0, t.min, 1'b0, t.sec};
   endfunction

   function automatic tk_cal_t unpack_cal(input logic [WORD_W-1:0] w);
      tk_cal_t c;
      c.cent  = w[6:0];
      c.year  = w[15:8];
      c.month = w[20:16];
      c.dow   = w[23:21];
      c.date  = w[29:24];
      return c;
   endfunction

   function automatic logic [WORD_W-1:0] pack_cal(input tk_cal_t c);
      return {2'd0, c.date, c.dow, c.month, c.year, 1'b0, c.cent};
   endfunction

endpackage

// File: rtl/bcd_tk_wrapcnt.sv
module bcd_tk_wrapcnt import bcd_tk_pkg::*; #(
   parameter int           W     = 7,
   parameter logic [W-1:0] FIRST = '0,
   parameter logic [W-1:0] LAST  = '1,
   parameter logic [W-1:0] RST   = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc_i,
   input  logic         ld_i,
   input  logic [W-1:0] ld_val_i,
   output logic [W-1:0] q_o,
   output logic         carry_o
);

   if (W < 1 || W > 8) begin : g_bad_width
      $error("bcd_tk_wrapcnt: W must lie in 1..8");
   end

   logic [W-1:0] q_q, q_d;
   logic         at_last;

   assign at_last = (q_q == LAST);
   assign carry_o = inc_i & at_last;
   assign q_o     = q_q;

   always_comb begin
      q_d = q_q;
      if (ld_i)       q_d = ld_val_i;
      else if (inc_i) q_d = at_last ? FIRST : W'(bcd_inc(8'(q_q)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_q <= RST;
      else        q_q <= q_d;
   end

   // R3: a digit pair moves only when stepped or loaded
   p_idle_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_i && !ld_i) |=> $stable(q_q));

   // R3 / R7: stepping from the last value returns to the first
   p_wrap_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !ld_i && q_q == LAST) |=> (q_q == FIRST));

endmodule

// File: rtl/bcd_tk_divider.sv
module bcd_tk_divider #(
   parameter int W = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   output logic tick_o
);

   if (W < 1 || W > 24) begin : g_bad_width
      $error("bcd_tk_divider: W must lie in 1..24");
   end

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (en_i) cnt_q <= cnt_q + W'(1);
   end

   assign tick_o = en_i & (&cnt_q);

   // R12: second pulses are single-cycle
   p_tick_gap_r12: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o);

endmodule

// File: rtl/bcd_tk_time.sv
module bcd_tk_time import bcd_tk_pkg::*; #(
   parameter tk_time_t RST = '0
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     adv_i,
   input  logic     mode12_i,
   input  logic     ld_i,
   input  tk_time_t ld_val_i,
   output tk_time_t time_o,
   output logic     day_carry_o
);

   logic [6:0] sec_q, min_q;
   logic       sec_c, min_c;
   logic [5:0] hour_q, hour_d;
   logic       pm_q, pm_d;

   bcd_tk_wrapcnt #(.W(7), .FIRST(7'h00), .LAST(7'h59), .RST(RST.sec)) u_sec (
      .clk(clk), .rst_n(rst_n), .inc_i(adv_i), .ld_i(ld_i),
      .ld_val_i(ld_val_i.sec), .q_o(sec_q), .carry_o(sec_c));

   bcd_tk_wrapcnt #(.W(7), .FIRST(7'h00), .LAST(7'h59), .RST(RST.min)) u_min (
      .clk(clk), .rst_n(rst_n), .inc_i(sec_c), .ld_i(ld_i),
      .ld_val_i(ld_val_i.min), .q_o(min_q), .carry_o(min_c));

   always_comb begin
      hour_d = hour_q;
      pm_d   = pm_q;
      if (ld_i) begin
         hour_d = ld_val_i.hour;
         pm_d   = ld_val_i.pm;
      end else if (min_c) begin
         if (mode12_i) begin
            hour_d = (hour_q == 6'h12) ? 6'h01 : 6'(bcd_inc({2'b00, hour_q}));
            if (hour_q == 6'h11) pm_d = ~pm_q;
         end else begin
            hour_d = (hour_q == 6'h23) ? 6'h00 : 6'(bcd_inc({2'b00, hour_q}));
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hour_q <= RST.hour;
         pm_q   <= RST.pm;
      end else begin
         hour_q <= hour_d;
         pm_q   <= pm_d;
      end
   end

   assign day_carry_o = min_c & (mode12_i ? (hour_q == 6'h11 && pm_q) : (hour_q == 6'h23));

   assign time_o = '{pm: pm_q, hour: hour_q, min: min_q, sec: sec_q};

   // R5: the 11 -> 12 step in 12-hour counting flips the PM flag
   p_pm_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_i && mode12_i && min_c && hour_q == 6'h11) |=> (pm_q != $past(pm_q)));

endmodule

// File: rtl/bcd_tk_date.sv
module bcd_tk_date import bcd_tk_pkg::*; #(
   parameter tk_cal_t RST = '0
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    adv_i,
   input  logic    ld_i,
   input  tk_cal_t ld_val_i,
   output tk_cal_t cal_o
);

   logic [5:0] date_q;
   logic [2:0] dow_q;
   logic [6:0] cent_q;
   logic [4:0] month_q;
   logic [7:0] year_q;
   logic       date_last, mon_c, yr_c;

   assign date_last = (date_q == month_last_date(month_q, year_q));

   bcd_tk_wrapcnt #(.W(5), .FIRST(5'h01), .LAST(5'h12), .RST(RST.month)) u_month (
      .clk(clk), .rst_n(rst_n), .inc_i(adv_i & date_last), .ld_i(ld_i),
      .ld_val_i(ld_val_i.month), .q_o(month_q), .carry_o(mon_c));

   bcd_tk_wrapcnt #(.W(8), .FIRST(8'h00), .LAST(8'h99), .RST(RST.year)) u_year (
      .clk(clk), .rst_n(rst_n), .inc_i(mon_c), .ld_i(ld_i),
      .ld_val_i(ld_val_i.year), .q_o(year_q), .carry_o(yr_c));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         date_q <= RST.date;
         dow_q  <= RST.dow;
         cent_q <= RST.cent;
      end else if (ld_i) begin
         date_q <= ld_val_i.date;
         dow_q  <= ld_val_i.dow;
         cent_q <= ld_val_i.cent;
      end else begin
         if (adv_i) begin
            date_q <= date_last ? 6'h01 : 6'(bcd_inc({2'b00, date_q}));
            dow_q  <= (dow_q == 3'd7) ? 3'd1 : dow_q + 3'd1;
         end
         if (yr_c) cent_q <= (cent_q == 7'h19) ? 7'h20 : 7'h19;
      end
   end

   assign cal_o = '{date: date_q, dow: dow_q, month: month_q, year: year_q, cent: cent_q};

   // R8: day of week wraps from 7 to 1
   p_dow_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && !ld_i && dow_q == 3'd7) |=> (dow_q == 3'd1));

   // R6: the date never moves without an advance or a load
   p_date_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv_i && !ld_i) |=> $stable(date_q));

endmodule

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper import bcd_tk_pkg::*; #(
   parameter int          DIV_W        = 15,
   parameter bit          BYPASS_DIV   = 1'b0,
   parameter logic [31:0] RST_CAL_WORD = 32'h0181_9819
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_in_i,
   input  logic              mode_12h_i,
   input  logic              time_hold_i,
   input  logic              cal_hold_i,
   output logic              upd_ack_o,
   input  logic              time_ld_i,
   input  logic [WORD_W-1:0] time_wdata_i,
   input  logic              cal_ld_i,
   input  logic [WORD_W-1:0] cal_wdata_i,
   output logic [WORD_W-1:0] time_o,
   output logic [WORD_W-1:0] cal_o,
   output logic              sec_tick_o
);

   localparam tk_cal_t  RST_CAL  = unpack_cal(RST_CAL_WORD);
   localparam tk_time_t RST_TIME = '0;

   if (DIV_W < 1 || DIV_W > 24) begin : g_bad_div
      $error("bcd_timekeeper: DIV_W must lie in 1..24");
   end

   logic     sec_tick, ack_q, pend_q, pend_d;
   logic     time_ld_ok, cal_ld_ok, time_adv, cal_adv, day_carry;
   tk_time_t time_cur;
   tk_cal_t  cal_cur;
   logic     unused_wbits;

   assign unused_wbits = ^{time_wdata_i[31:23], time_wdata_i[15], time_wdata_i[7],
                           cal_wdata_i[31:30], cal_wdata_i[7]};

   if (BYPASS_DIV) begin : g_bypass
      assign sec_tick = tick_in_i;
   end else begin : g_div
      bcd_tk_divider #(.W(DIV_W)) u_div (
         .clk(clk), .rst_n(rst_n), .en_i(tick_in_i), .tick_o(sec_tick));
   end

   // hold handshake: counters stop at once, acknowledge follows one edge later
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         ack_q  <= time_hold_i | cal_hold_i;
         pend_q <= pend_d;
      end
   end

   assign time_ld_ok = time_ld_i & time_hold_i & ack_q;
   assign cal_ld_ok  = cal_ld_i & cal_hold_i & ack_q;
   assign time_adv   = sec_tick & ~time_hold_i;
   assign cal_adv    = ~cal_hold_i & (day_carry | pend_q);

   always_comb begin
      if (!cal_hold_i)    pend_d = 1'b0;
      else if (cal_ld_ok) pend_d = day_carry;
      else                pend_d = pend_q | day_carry;
   end

   bcd_tk_time #(.RST(RST_TIME)) u_time (
      .clk(clk), .rst_n(rst_n), .adv_i(time_adv), .mode12_i(mode_12h_i),
      .ld_i(time_ld_ok), .ld_val_i(unpack_time(time_wdata_i)),
      .time_o(time_cur), .day_carry_o(day_carry));

   bcd_tk_date #(.RST(RST_CAL)) u_date (
      .clk(clk), .rst_n(rst_n), .adv_i(cal_adv), .ld_i(cal_ld_ok),
      .ld_val_i(unpack_cal(cal_wdata_i)), .cal_o(cal_cur));

   assign time_o     = pack_time(time_cur);
   assign cal_o      = pack_cal(cal_cur);
   assign upd_ack_o  = ack_q;
   assign sec_tick_o = sec_tick;

   // R11: no acknowledge without a request in the previous cycle
   p_ack_needs_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
      upd_ack_o |-> $past(time_hold_i || cal_hold_i));

   // R9: held time word only changes through an accepted load
   p_time_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (time_hold_i && !time_ld_ok) |=> $stable(time_o));

   // R9: held calendar word only changes through an accepted load
   p_cal_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_hold_i && !cal_ld_ok) |=> $stable(cal_o));

   // R10: a midnight during the calendar hold is remembered
   p_midnight_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_hold_i && day_carry) |=> pend_q);

endmodule

// File: tb/bcd_timekeeper_tb_top.sv
module bcd_timekeeper_tb_top;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0, m12 = 1'b0, th = 1'b0, ch = 1'b0;
   logic        tld = 1'b0, cld = 1'b0;
   logic [31:0] twd = '0, cwd = '0;
   logic        ack, stk;
   logic [31:0] tout, cout;
   logic        dv_ack, dv_stk;
   logic [31:0] dv_time, dv_cal;

   int nvec = 0, nfail = 0;
   bit done = 1'b0;

   // bench model
   int ms, yy, mm, dd, wd;
   bit mpend;

   always #(CLK_P/2) clk = ~clk;

   bcd_timekeeper #(.DIV_W(15), .BYPASS_DIV(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick_in_i(tick), .mode_12h_i(m12),
      .time_hold_i(th), .cal_hold_i(ch), .upd_ack_o(ack),
      .time_ld_i(tld), .time_wdata_i(twd), .cal_ld_i(cld), .cal_wdata_i(cwd),
      .time_o(tout), .cal_o(cout), .sec_tick_o(stk));

   bcd_timekeeper #(.DIV_W(3), .BYPASS_DIV(1'b0)) div_i (
      .clk(clk), .rst_n(rst_n), .tick_in_i(1'b1), .mode_12h_i(1'b0),
      .time_hold_i(1'b0), .cal_hold_i(1'b0), .upd_ack_o(dv_ack),
      .time_ld_i(1'b0), .time_wdata_i(32'd0), .cal_ld_i(1'b0), .cal_wdata_i(32'd0),
      .time_o(dv_time), .cal_o(dv_cal), .sec_tick_o(dv_stk));

   function automatic logic [7:0] bcd8(input int n);
      return 8'(((n / 10) * 16) + (n % 10));
   endfunction

   function automatic int mdays(input int m, input int y);
      if (m == 2) return (y % 4 == 0) ? 29 : 28;
      if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
      return 31;
   endfunction

   function automatic logic [31:0] exp_time();
      int h, hh;
      logic [7:0] bs, bm, bh;
      logic pm;
      h  = ms / 3600;
      bs = bcd8(ms % 60);
      bm = bcd8((ms / 60) % 60);
      if (m12) begin
         hh = (h % 12 == 0) ? 12 : h % 12;
         pm = (h >= 12);
      end else begin
         hh = h;
         pm = 1'b0;
      end
      bh = bcd8(hh);
      return {9'd0, pm, bh[5:0], 1'b0, bm[6:0], 1'b0, bs[6:0]};
   endfunction

   function automatic logic [31:0] exp_cal();
      logic [7:0] by, bc, bd, bmo;
      by  = bcd8(yy % 100);
      bc  = bcd8(yy / 100);
      bd  = bcd8(dd);
      bmo = bcd8(mm);
      return {2'd0, bd[5:0], 3'(wd), bmo[4:0], by, 1'b0, bc[6:0]};
   endfunction

   task automatic model_day();
      wd = (wd == 7) ? 1 : wd + 1;
      dd++;
      if (dd > mdays(mm, yy)) begin
         dd = 1;
         mm++;
         if (mm > 12) begin
            mm = 1;
            yy++;
            if (yy > 2099) yy = 1900;
         end
      end
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
   endtask

   // all tasks start and end right after a falling edge
   task automatic run_ticks(input int n, input string req);
      tick = 1'b1;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (!th) begin
            ms++;
            if (ms == 86400) begin
               ms = 0;
               if (ch) mpend = 1'b1;
               else    model_day();
            end
         end
         chk(req, tout, exp_time());
         chk(req, cout, exp_cal());
      end
      tick = 1'b0;
   endtask

   task automatic set_time(input int h, input int m, input int s);
      ms  = h * 3600 + m * 60 + s;
      th  = 1'b1;
      @(negedge clk);
      tld = 1'b1;
      twd = exp_time();
      @(negedge clk);
      tld = 1'b0;
      th  = 1'b0;
      @(negedge clk);
   endtask

   task automatic set_cal(input int y, input int m, input int d, input int w);
      logic old;
      old = ch;
      ch  = 1'b1;
      @(negedge clk);
      yy = y; mm = m; dd = d; wd = w; mpend = 1'b0;
      cld = 1'b1;
      cwd = exp_cal();
      @(negedge clk);
      cld = 1'b0;
      ch  = old;
      @(negedge clk);
   endtask

   task automatic release_cal(input string req);
      ch = 1'b0;
      @(negedge clk);
      if (mpend) begin
         model_day();
         mpend = 1'b0;
      end
      chk(req, cout, exp_cal());
      chk(req, tout, exp_time());
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: actual hung expected finished");
         report();
         $finish;
      end
   end

   initial begin : main
      logic [31:0] hold_t;
      ms = 0; yy = 1998; mm = 1; dd = 1; wd = 4; mpend = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      chk("R1", tout, 32'h0000_0000);
      chk("R1", cout, 32'h0181_9819);
      chk("R1", cout, exp_cal());
      chk("R1", {31'd0, ack}, 32'd0);

      // R12: prescaler with width 3 pulses every 8 cycles
      for (int i = 1; i <= 64; i++) begin
         @(negedge clk);
         chk("R12", {31'd0, dv_stk}, {31'd0, (i % 8 == 7)});
      end
      chk("R12", dv_time, 32'h0000_0008);
      chk("R1", tout, 32'h0000_0000);

      // R2: field positions and zero-reading bits
      th = 1'b1;
      @(negedge clk);
      tld = 1'b1;
      twd = 32'hFF80_8080 | 32'h0013_4527;
      @(negedge clk);
      tld = 1'b0; th = 1'b0;
      @(negedge clk);
      ms = 13 * 3600 + 45 * 60 + 27;
      chk("R2", tout, 32'h0013_4527);
      set_cal(2021, 7, 15, 3);
      chk("R2", cout, 32'h1567_2120);

      // R11: loads without hold/acknowledge are ignored
      tld = 1'b1; twd = 32'h0001_0203;
      @(negedge clk);
      chk("R11", tout, exp_time());
      chk("R11", {31'd0, ack}, 32'd0);
      th = 1'b1;
      @(negedge clk);
      chk("R11", {31'd0, ack}, 32'd1);
      chk("R11", tout, exp_time());
      tld = 1'b0;
      cld = 1'b1; cwd = 32'h0101_0119;
      @(negedge clk);
      chk("R11", cout, exp_cal());
      cld = 1'b0; th = 1'b0;
      @(negedge clk);
      chk("R11", {31'd0, ack}, 32'd0);

      // R3 and R4: one full day in 24-hour counting
      m12 = 1'b0;
      set_time(0, 0, 0);
      run_ticks(86400, "R3/R4");

      // R5: every hour boundary in 12-hour counting
      m12 = 1'b1;
      for (int h = 0; h < 24; h++) begin
         set_time(h, 59, 58);
         run_ticks(3, "R5");
      end
      m12 = 1'b0;

      // R6, R7, R8: calendar sweeps across leap years and century changes
      set_cal(1900, 1, 1, 1);
      for (int i = 0; i < 800; i++) begin
         set_time(23, 59, 59);
         run_ticks(1, "R6/R7/R8");
      end
      set_cal(1999, 12, 20, 1);
      for (int i = 0; i < 500; i++) begin
         set_time(23, 59, 59);
         run_ticks(1, "R6/R7/R8");
      end
      set_cal(2099, 12, 20, 5);
      for (int i = 0; i < 20; i++) begin
         set_time(23, 59, 59);
         run_ticks(1, "R6/R7/R8");
      end

      // R9: time hold freezes time and calendar stays put
      set_time(10, 0, 0);
      hold_t = tout;
      th = 1'b1;
      run_ticks(5, "R9");
      chk("R9", tout, hold_t);
      th = 1'b0;
      @(negedge clk);

      // R9 and R10: calendar hold, time crosses midnight
      ch = 1'b1;
      @(negedge clk);
      set_time(23, 59, 58);
      run_ticks(4, "R9");
      release_cal("R10");
      run_ticks(3, "R10");

      // R13: calendar load in the same cycle as a held midnight
      ch = 1'b1;
      @(negedge clk);
      set_time(23, 59, 59);
      yy = 2024; mm = 2; dd = 28; wd = 3;
      cld = 1'b1; cwd = exp_cal(); tick = 1'b1;
      @(negedge clk);
      cld = 1'b0; tick = 1'b0;
      ms = 0; mpend = 1'b1;
      chk("R13", cout, exp_cal());
      chk("R13", tout, exp_time());
      release_cal("R13");
      chk("R13", cout, 32'h2982_2420);

      // R13: a midnight recorded before a load is discarded
      ch = 1'b1;
      @(negedge clk);
      set_time(23, 59, 59);
      run_ticks(1, "R13");
      set_cal(2030, 5, 5, 6);
      release_cal("R13");
      run_ticks(2, "R13");

      done = 1'b1;
      report();
      $finish;
   end

endmodule